// File: doc/BRIEF.md
# Character LCD Instruction Executor

This block is the command engine of a character display controller. A bus front end hands it one request at a time: an instruction byte, a data byte to store, a data read, or a status read. The engine decodes each instruction, keeps the address counter, the entry mode, the display, cursor and blink flags, the interface, line-count and font flags and a display shift offset. It also owns the display character memory and the user glyph memory, and writes and reads them on the data path.

Every accepted request except a status read raises a busy flag for a fixed number of display-clock cycles that depends on the request kind. While busy, further requests are dropped; only the status read (busy flag plus address counter) is answered. After reset the engine runs a full clear and settles into a fixed default mode, busy all the while. The state flags and the shift offset are brought out as ports for the scan logic that sits beside it.

Top module: `lcd_cmd_core`

## Requirements
- R1: An instruction byte is decoded by its highest set bit: bit 7 loads a 7-bit display address from bits 6..0, bit 6 loads a 6-bit glyph address from bits 5..0, bit 5 is function set, bit 4 is cursor/display shift, bit 3 is display control, bit 2 is entry mode, bit 1 is return home and bit 0 alone is clear; the lower bits below the leading one only carry fields of that instruction.
- R2: Clear writes 0x20 into all 80 display locations, sets the address counter to 0, selects the display memory, sets the shift offset to 0 and forces increment mode; busy lasts CLEAR_CYC cycles and the fill completes inside that window.
- R3: Return home sets the address counter and the shift offset to 0 and selects the display memory, without changing any stored character.
- R4: Display addresses step with wrap: in two-line mode 0x27+1 gives 0x40, 0x67+1 gives 0x00, 0x40-1 gives 0x27 and 0x00-1 gives 0x67; in one-line mode 0x4F+1 gives 0x00 and 0x00-1 gives 0x4F.
- R5: Each data read or write steps the address counter by +1 when increment mode is set and by -1 otherwise; glyph addresses wrap within 6 bits (0x3F+1 gives 0x00).
- R6: With entry shift set, a display-memory write also moves the shift offset by one: +1 (left) in increment mode, -1 (right) in decrement mode, modulo 40 in two-line mode and 80 in one-line mode; reads and glyph writes leave the offset unchanged.
- R7: For the shift instruction, bit 3 = 0 moves the address counter (bit 2 = 1 forward, 0 backward, same wrap as R4); bit 3 = 1 moves the shift offset (bit 2 = 0 left, +1; bit 2 = 1 right, -1) and leaves the address counter unchanged.
- R8: Busy lasts CLEAR_CYC (410) cycles after clear and home, INSTR_CYC (10) after other instructions and DATA_CYC (12) after data reads and writes; a status read takes no time and returns busy in bit 7 and the address counter in bits 6..0.
- R9: Instructions and data requests presented while busy are ignored: no flag, address, offset or memory changes.
- R10: After reset the block is busy through a full clear and then reports 8-bit interface, one line, short font, display, cursor and blink off, increment mode and no entry shift.
- R11: The most recent address-load instruction selects the memory for data accesses (glyph after a bit-6 load, display after a bit-7 load, clear or home), shown on cg_target; accesses to one memory leave the other unchanged.
- R12: Function set stores bit 4 as 8-bit interface, bit 3 as two-line mode and bit 2 as tall font; display control stores bit 2 as display on, bit 1 as cursor on and bit 0 as blink on; entry mode stores bit 1 as increment and bit 0 as entry shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present for this cycle |
| req_data | input | 1 | 1 = data register access, 0 = instruction/status |
| req_read | input | 1 | 1 = read, 0 = write |
| req_byte | input | 8 | Instruction or write data |
| rd_byte | output | 8 | Result of the last read (data or status) |
| busy | output | 1 | Execution in progress |
| addr_cnt | output | 7 | Address counter |
| cg_target | output | 1 | Data accesses go to glyph memory |
| entry_inc | output | 1 | Increment mode |
| entry_shift | output | 1 | Display shift on write |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blink enabled |
| bus_8bit | output | 1 | 8-bit interface width selected |
| two_line | output | 1 | Two-line mode |
| font_tall | output | 1 | Tall font selected |
| shift_ofs | output | 7 | Display shift offset in positions to the left |

## Verification
The bench aims at the seams of the address map: stepping across 0x27/0x40 and 0x67/0x00 in both directions, the one-line 0x4F/0x00 edge and the 6-bit glyph wrap; a design with a flat 7-bit counter would land on 0x28 or 0x68 and read back the wrong character. The shift offset is driven through its wrap in both line modes, so a design using a single modulus or shifting on reads and glyph writes shows a wrong offset. Requests issued in the middle of a busy window must leave the counter, the flags and the memory untouched, which catches an engine that accepts work early. Bytes with many low bits set (0x3F, 0x0F, 0x07) check that decode keys on the leading one rather than on a lower bit.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_DISP,
    OP_SHIFT,
    OP_FUNC,
    OP_CGADDR,
    OP_DDADDR
  } lcd_op_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;

endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
  import lcd_pkg::*;
(
  input  logic [7:0] code,
  output lcd_op_e    op
);

  // Leading one wins (R1)
  always_comb begin
    casez (code)
      8'b1???????: op = OP_DDADDR;
      8'b01??????: op = OP_CGADDR;
      8'b001?????: op = OP_FUNC;
      8'b0001????: op = OP_SHIFT;
      8'b00001???: op = OP_DISP;
      8'b000001??: op = OP_ENTRY;
      8'b0000001?: op = OP_HOME;
      8'b00000001: op = OP_CLEAR;
      default:     op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step #(
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int CGW        = 6,
  parameter int AW         = 7
) (
  input  logic [AW-1:0] addr,
  input  logic          up,
  input  logic          to_cg,
  input  logic          lines2,
  output logic [AW-1:0] nxt
);

  localparam logic [AW-1:0] L1_LAST  = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_FIRST = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_LAST  = AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AW-1:0] ONE_LAST = AW'(2 * LINE_LEN - 1);

  logic [CGW-1:0] cg_nxt;

  always_comb begin
    cg_nxt = up ? addr[CGW-1:0] + CGW'(1) : addr[CGW-1:0] - CGW'(1);
    if (to_cg) begin
      nxt = AW'(cg_nxt);
    end else if (lines2) begin
      if (up) begin
        if (addr == L1_LAST)      nxt = L2_FIRST;
        else if (addr == L2_LAST) nxt = '0;
        else                      nxt = addr + AW'(1);
      end else begin
        if (addr == L2_FIRST)     nxt = L1_LAST;
        else if (addr == '0)      nxt = L2_LAST;
        else                      nxt = addr - AW'(1);
      end
    end else begin
      if (up) nxt = (addr == ONE_LAST) ? '0 : addr + AW'(1);
      else    nxt = (addr == '0) ? ONE_LAST : addr - AW'(1);
    end
  end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CW      = 9,
  parameter int RST_VAL = 410
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_busy_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);

endmodule

// File: rtl/lcd_char_store.sv
module lcd_char_store #(
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64,
  parameter int DDW      = 7,
  parameter int CGW      = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic           w_cg,
  input  logic [DDW-1:0] w_idx,
  input  logic [7:0]     w_data,
  input  logic           r_cg,
  input  logic [DDW-1:0] r_idx,
  output logic [7:0]     r_data
);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (w_cg)                          cg_mem[w_idx[CGW-1:0]] <= w_data;
      else if (int'(w_idx) < DD_DEPTH)   dd_mem[w_idx]          <= w_data;
    end
  end

  always_comb begin
    if (r_cg)                          r_data = cg_mem[r_idx[CGW-1:0]];
    else if (int'(r_idx) < DD_DEPTH)   r_data = dd_mem[r_idx];
    else                               r_data = 8'h00;
  end

endmodule

// File: rtl/lcd_cmd_core.sv
module lcd_cmd_core
  import lcd_pkg::*;
#(
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int CG_DEPTH   = 64,
  parameter int CLEAR_CYC  = 410,
  parameter int INSTR_CYC  = 10,
  parameter int DATA_CYC   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_data,
  input  logic       req_read,
  input  logic [7:0] req_byte,
  output logic [7:0] rd_byte,
  output logic       busy,
  output logic [6:0] addr_cnt,
  output logic       cg_target,
  output logic       entry_inc,
  output logic       entry_shift,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       font_tall,
  output logic [6:0] shift_ofs
);

  localparam int AW       = 7;
  localparam int DD_DEPTH = 2 * LINE_LEN;
  localparam int DDW      = $clog2(DD_DEPTH);
  localparam int CGW      = $clog2(CG_DEPTH);
  localparam int MAX_AB   = (CLEAR_CYC > INSTR_CYC) ? CLEAR_CYC : INSTR_CYC;
  localparam int MAXC     = (MAX_AB > DATA_CYC) ? MAX_AB : DATA_CYC;
  localparam int CNTW     = $clog2(MAXC + 1);
  localparam logic [AW-1:0]  LEN_TWO  = AW'(LINE_LEN);
  localparam logic [AW-1:0]  LEN_ONE  = AW'(DD_DEPTH);
  localparam logic [AW-1:0]  BASE2    = AW'(LINE2_BASE);
  localparam logic [DDW-1:0] FILL_END = DDW'(DD_DEPTH - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_i, rst_meta} <= 2'b00;
    else        {rst_i, rst_meta} <= {rst_meta, 1'b1};
  end

  // state
  logic [AW-1:0]  ac_q, ac_d, ofs_q, ofs_d;
  logic           cg_q, cg_d, inc_q, inc_d, esh_q, esh_d;
  logic           don_q, don_d, con_q, con_d, bon_q, bon_d;
  logic           dl_q, dl_d, nl_q, nl_d, ft_q, ft_d;
  logic           clr_q, clr_d;
  logic [DDW-1:0] fill_q, fill_d;
  logic [7:0]     rd_q, rd_d;

  // request classification
  lcd_op_e op;
  logic status_rd, acc, instr, data_wr, data_rd, cmd_exec;
  logic step_up;
  logic [AW-1:0] ac_step;

  lcd_op_decode u_dec (.code(req_byte), .op(op));

  assign status_rd = req_valid && !req_data && req_read;
  assign acc       = req_valid && !busy && !status_rd;
  assign instr     = acc && !req_data;
  assign data_wr   = acc && req_data && !req_read;
  assign data_rd   = acc && req_data && req_read;
  assign cmd_exec  = instr && (op != OP_NOP);
  assign step_up   = (instr && op == OP_SHIFT) ? req_byte[2] : inc_q;

  lcd_addr_step #(
    .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE), .CGW(CGW), .AW(AW)
  ) u_step (
    .addr(ac_q), .up(step_up), .to_cg(cg_q), .lines2(nl_q), .nxt(ac_step)
  );

  // busy timing per request kind
  logic            tm_load;
  logic [CNTW-1:0] tm_val;

  always_comb begin
    tm_load = cmd_exec || data_wr || data_rd;
    if (!req_data && (op == OP_CLEAR || op == OP_HOME)) tm_val = CNTW'(CLEAR_CYC);
    else if (!req_data)                                  tm_val = CNTW'(INSTR_CYC);
    else                                                 tm_val = CNTW'(DATA_CYC);
  end

  lcd_busy_timer #(.CW(CNTW), .RST_VAL(CLEAR_CYC)) u_busy (
    .clk(clk), .rst_n(rst_i), .load(tm_load), .load_val(tm_val), .busy(busy)
  );

  // display address to physical slot
  logic [AW-1:0]  rel;
  logic [DDW-1:0] dd_idx;
  logic           dd_ok;

  always_comb begin
    rel = ac_q - BASE2;
    if (nl_q) begin
      if (ac_q >= BASE2) begin
        dd_ok  = (rel < LEN_TWO);
        dd_idx = DDW'(LEN_TWO + rel);
      end else begin
        dd_ok  = (ac_q < LEN_TWO);
        dd_idx = DDW'(ac_q);
      end
    end else begin
      dd_ok  = (ac_q < LEN_ONE);
      dd_idx = DDW'(ac_q);
    end
  end

  // character storage
  logic           st_we, st_wcg;
  logic [DDW-1:0] st_widx, st_ridx;
  logic [7:0]     st_wdata, st_rdata;

  always_comb begin
    st_ridx = cg_q ? DDW'(ac_q[CGW-1:0]) : dd_idx;
    if (clr_q) begin
      st_we    = 1'b1;
      st_wcg   = 1'b0;
      st_widx  = fill_q;
      st_wdata = BLANK_CODE;
    end else begin
      st_we    = data_wr && (cg_q || dd_ok);
      st_wcg   = cg_q;
      st_widx  = st_ridx;
      st_wdata = req_byte;
    end
  end

  lcd_char_store #(
    .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .DDW(DDW), .CGW(CGW)
  ) u_store (
    .clk(clk), .we(st_we), .w_cg(st_wcg), .w_idx(st_widx), .w_data(st_wdata),
    .r_cg(cg_q), .r_idx(st_ridx), .r_data(st_rdata)
  );

  // shift offset arithmetic
  logic [AW-1:0] len, ofs_left, ofs_right;
  logic          ent_sh, cmd_sh;

  always_comb begin
    len       = nl_q ? LEN_TWO : LEN_ONE;
    ofs_left  = (ofs_q + AW'(1) >= len) ? '0 : ofs_q + AW'(1);
    ofs_right = (ofs_q == '0) ? len - AW'(1) : ofs_q - AW'(1);
    ent_sh    = data_wr && !cg_q && esh_q;
    cmd_sh    = instr && (op == OP_SHIFT) && req_byte[3];
  end

  // next state
  always_comb begin
    ac_d = ac_q;   ofs_d = ofs_q;  cg_d = cg_q;   inc_d = inc_q; esh_d = esh_q;
    don_d = don_q; con_d = con_q;  bon_d = bon_q;
    dl_d = dl_q;   nl_d = nl_q;    ft_d = ft_q;
    clr_d = clr_q; fill_d = fill_q; rd_d = rd_q;

    if (clr_q) begin
      fill_d = fill_q + DDW'(1);
      if (fill_q == FILL_END) clr_d = 1'b0;
    end

    if (status_rd) rd_d = {busy, ac_q};

    if (data_rd) rd_d = (cg_q || dd_ok) ? st_rdata : 8'h00;

    if (data_wr || data_rd) ac_d = ac_step;

    if (ent_sh) ofs_d = inc_q ? ofs_left : ofs_right;

    if (instr) begin
      unique case (op)
        OP_CLEAR: begin
          ac_d = '0; cg_d = 1'b0; ofs_d = '0; inc_d = 1'b1;
          clr_d = 1'b1; fill_d = '0;
        end
        OP_HOME: begin
          ac_d = '0; cg_d = 1'b0; ofs_d = '0;
        end
        OP_ENTRY: begin
          inc_d = req_byte[1]; esh_d = req_byte[0];
        end
        OP_DISP: begin
          don_d = req_byte[2]; con_d = req_byte[1]; bon_d = req_byte[0];
        end
        OP_SHIFT: begin
          if (cmd_sh) ofs_d = req_byte[2] ? ofs_right : ofs_left;
          else        ac_d  = ac_step;
        end
        OP_FUNC: begin
          dl_d = req_byte[4]; nl_d = req_byte[3]; ft_d = req_byte[2];
        end
        OP_CGADDR: begin
          ac_d = AW'(req_byte[CGW-1:0]); cg_d = 1'b1;
        end
        OP_DDADDR: begin
          ac_d = req_byte[6:0]; cg_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  // registers; reset state enters the power-on clear
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ac_q  <= '0;   ofs_q <= '0;   cg_q  <= 1'b0; inc_q <= 1'b1; esh_q <= 1'b0;
      don_q <= 1'b0; con_q <= 1'b0; bon_q <= 1'b0;
      dl_q  <= 1'b1; nl_q  <= 1'b0; ft_q  <= 1'b0;
      clr_q <= 1'b1; fill_q <= '0;  rd_q  <= '0;
    end else begin
      ac_q  <= ac_d;  ofs_q <= ofs_d; cg_q  <= cg_d;  inc_q <= inc_d; esh_q <= esh_d;
      don_q <= don_d; con_q <= con_d; bon_q <= bon_d;
      dl_q  <= dl_d;  nl_q  <= nl_d;  ft_q  <= ft_d;
      clr_q <= clr_d; fill_q <= fill_d; rd_q <= rd_d;
    end
  end

  assign rd_byte     = rd_q;
  assign addr_cnt    = ac_q;
  assign cg_target   = cg_q;
  assign entry_inc   = inc_q;
  assign entry_shift = esh_q;
  assign disp_on     = don_q;
  assign cursor_on   = con_q;
  assign blink_on    = bon_q;
  assign bus_8bit    = dl_q;
  assign two_line    = nl_q;
  assign font_tall   = ft_q;
  assign shift_ofs   = ofs_q;

  // checks beside the logic they guard
  logic ac_in_lines, step_evt;
  assign ac_in_lines = (ac_q < LEN_TWO) || ((ac_q >= BASE2) && (ac_q < BASE2 + LEN_TWO));
  assign step_evt    = data_wr || data_rd || (instr && op == OP_SHIFT && !req_byte[3]);

  assert_line_wrap_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (step_evt && !cg_q && nl_q && ac_in_lines) |=> ac_in_lines);

  assert_shift_in_range_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (ent_sh || cmd_sh) |=> (ofs_q < len));

  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_i)
    busy |=> ($stable(ac_q) && $stable(ofs_q) && $stable(nl_q) && $stable(don_q)));

  assert_fill_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_i)
    clr_q |-> busy);

  assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_exec || data_wr || data_rd) |=> busy);

endmodule

// File: tb/tb_lcd_cmd_core.sv
module tb_lcd_cmd_core;

  localparam int CLK_NS   = 10;
  localparam int T_CLEAR  = 410;
  localparam int T_INSTR  = 10;
  localparam int T_DATA   = 12;
  localparam int WD_LIMIT = 100000;

  logic       clk, rst_n;
  logic       req_valid, req_data, req_read;
  logic [7:0] req_byte, rd_byte;
  logic       busy, cg_target, entry_inc, entry_shift;
  logic       disp_on, cursor_on, blink_on, bus_8bit, two_line, font_tall;
  logic [6:0] addr_cnt, shift_ofs;

  int n_chk, n_fail;
  bit done;

  lcd_cmd_core dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_read(req_read), .req_byte(req_byte), .rd_byte(rd_byte), .busy(busy),
    .addr_cnt(addr_cnt), .cg_target(cg_target), .entry_inc(entry_inc),
    .entry_shift(entry_shift), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .bus_8bit(bus_8bit), .two_line(two_line),
    .font_tall(font_tall), .shift_ofs(shift_ofs)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic rs, input logic rw, input logic [7:0] b);
    wait_idle();
    req_valid = 1'b1; req_data = rs; req_read = rw; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] b);
    send(1'b0, 1'b0, b); wait_idle();
  endtask

  task automatic do_wr(input logic [7:0] b);
    send(1'b1, 1'b0, b); wait_idle();
  endtask

  task automatic do_rd(output logic [7:0] v);
    send(1'b1, 1'b1, 8'h00); v = rd_byte; wait_idle();
  endtask

  task automatic measure(input logic rs, input logic rw, input logic [7:0] b, output int n);
    send(rs, rw, b);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic status(output logic [7:0] v);
    req_valid = 1'b1; req_data = 1'b0; req_read = 1'b1; req_byte = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    v = rd_byte;
  endtask

  task automatic t_power_on();
    logic [7:0] v;
    rst_n = 1'b0; req_valid = 1'b0; req_data = 1'b0; req_read = 1'b0; req_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 busy held in reset", busy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after release", busy, 1);
    wait_idle();
    chk("R10 bus_8bit", bus_8bit, 1);
    chk("R10 two_line", two_line, 0);
    chk("R10 font_tall", font_tall, 0);
    chk("R10 disp/cursor/blink", {disp_on, cursor_on, blink_on}, 0);
    chk("R10 entry_inc", entry_inc, 1);
    chk("R10 entry_shift", entry_shift, 0);
    chk("R10 addr_cnt", addr_cnt, 0);
    chk("R10 shift_ofs", shift_ofs, 0);
    do_rd(v);
    chk("R10 R2 power-on blank at 0x00", v, 8'h20);
    do_cmd(8'hCF);
    do_rd(v);
    chk("R2 power-on blank at 0x4F", v, 8'h20);
    chk("R4 one-line 0x4F+1", addr_cnt, 7'h00);
  endtask

  task automatic t_decode();
    do_cmd(8'h3F);
    chk("R1 R12 0x3F is function set", {bus_8bit, two_line, font_tall}, 3'b111);
    chk("R1 0x3F leaves display flags", {disp_on, cursor_on, blink_on}, 3'b000);
    do_cmd(8'h0F);
    chk("R1 R12 0x0F display flags", {disp_on, cursor_on, blink_on}, 3'b111);
    do_cmd(8'h0A);
    chk("R12 0x0A display flags", {disp_on, cursor_on, blink_on}, 3'b010);
    do_cmd(8'h07);
    chk("R1 R12 0x07 entry", {entry_inc, entry_shift}, 2'b11);
    do_cmd(8'h06);
    do_cmd(8'h2C);
    chk("R12 0x2C function", {bus_8bit, two_line, font_tall}, 3'b011);
    do_cmd(8'h38);
    chk("R12 0x38 function", {bus_8bit, two_line, font_tall}, 3'b110);
  endtask

  task automatic t_two_line();
    logic [7:0] v;
    do_cmd(8'hA7);
    chk("R1 display address load", addr_cnt, 7'h27);
    do_wr(8'h41);
    chk("R4 two-line 0x27+1", addr_cnt, 7'h40);
    do_wr(8'h42);
    chk("R5 step +1", addr_cnt, 7'h41);
    do_cmd(8'hE7);
    do_wr(8'h43);
    chk("R4 two-line 0x67+1", addr_cnt, 7'h00);
    do_cmd(8'hA7);
    do_rd(v);
    chk("R5 read back 0x27", v, 8'h41);
    chk("R4 R5 read steps 0x27 to 0x40", addr_cnt, 7'h40);
    do_rd(v);
    chk("R5 read back 0x40", v, 8'h42);
    do_cmd(8'h04);
    do_cmd(8'hC0);
    do_wr(8'h44);
    chk("R4 two-line 0x40-1", addr_cnt, 7'h27);
    do_cmd(8'h80);
    do_wr(8'h45);
    chk("R4 two-line 0x00-1", addr_cnt, 7'h67);
    do_rd(v);
    chk("R5 read at 0x67", v, 8'h43);
    chk("R5 step -1", addr_cnt, 7'h66);
    do_cmd(8'h06);
  endtask

  task automatic t_one_line();
    do_cmd(8'h30);
    do_cmd(8'hCF);
    do_wr(8'h46);
    chk("R4 one-line 0x4F+1", addr_cnt, 7'h00);
    do_cmd(8'h04);
    do_cmd(8'h80);
    do_wr(8'h47);
    chk("R4 one-line 0x00-1", addr_cnt, 7'h4F);
    do_cmd(8'h06);
  endtask

  task automatic t_glyph();
    logic [7:0] v;
    do_cmd(8'h7F);
    chk("R11 glyph target", cg_target, 1);
    chk("R11 glyph address", addr_cnt, 7'h3F);
    do_wr(8'h1F);
    chk("R5 glyph wrap 0x3F+1", addr_cnt, 7'h00);
    do_wr(8'h11);
    do_cmd(8'h7F);
    do_rd(v);
    chk("R11 glyph read 0x3F", v, 8'h1F);
    do_rd(v);
    chk("R11 glyph read 0x00", v, 8'h11);
    do_cmd(8'h80);
    chk("R11 display target", cg_target, 0);
    do_rd(v);
    chk("R11 display slot 0 untouched by glyph write", v, 8'h47);
  endtask

  task automatic t_entry_shift();
    logic [7:0] v;
    do_cmd(8'h38);
    do_cmd(8'h02);
    do_cmd(8'h07);
    do_cmd(8'h80);
    do_wr(8'h50);
    chk("R6 write shifts left", shift_ofs, 7'd1);
    do_cmd(8'h05);
    do_wr(8'h51);
    chk("R6 write shifts right", shift_ofs, 7'd0);
    do_wr(8'h52);
    chk("R6 two-line right wrap", shift_ofs, 7'd39);
    do_rd(v);
    chk("R6 read does not shift", shift_ofs, 7'd39);
    do_cmd(8'h40);
    do_wr(8'h00);
    chk("R6 glyph write does not shift", shift_ofs, 7'd39);
    do_cmd(8'h30);
    do_cmd(8'h02);
    do_cmd(8'h80);
    do_wr(8'h53);
    chk("R6 one-line right wrap", shift_ofs, 7'd79);
    do_cmd(8'h06);
    do_cmd(8'h38);
  endtask

  task automatic t_shift_cmd();
    do_cmd(8'h02);
    do_cmd(8'hA7);
    do_cmd(8'h14);
    chk("R7 cursor right across line", addr_cnt, 7'h40);
    do_cmd(8'h10);
    chk("R7 cursor left across line", addr_cnt, 7'h27);
    do_cmd(8'h18);
    chk("R7 display left", shift_ofs, 7'd1);
    chk("R7 display shift keeps address", addr_cnt, 7'h27);
    do_cmd(8'h1C);
    do_cmd(8'h1C);
    chk("R7 display right wrap", shift_ofs, 7'd39);
  endtask

  task automatic t_home();
    logic [7:0] v;
    int n;
    do_cmd(8'h80);
    do_wr(8'h61);
    do_cmd(8'h18);
    do_cmd(8'h18);
    chk("R7 left wrap to 1", shift_ofs, 7'd1);
    measure(1'b0, 1'b0, 8'h02, n);
    chk("R8 home busy cycles", n, T_CLEAR);
    chk("R3 home address", addr_cnt, 7'h00);
    chk("R3 home offset", shift_ofs, 7'd0);
    do_rd(v);
    chk("R3 home keeps memory", v, 8'h61);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    int n;
    measure(1'b0, 1'b0, 8'h06, n);
    chk("R8 instruction busy cycles", n, T_INSTR);
    do_cmd(8'h80);
    measure(1'b1, 1'b0, 8'h62, n);
    chk("R8 write busy cycles", n, T_DATA);
    measure(1'b1, 1'b1, 8'h00, n);
    chk("R8 read busy cycles", n, T_DATA);
    status(v);
    chk("R8 status when idle", v, 8'h02);
    chk("R8 status takes no time", busy, 0);
    send(1'b0, 1'b0, 8'h06);
    status(v);
    chk("R8 status while busy", v, 8'h82);
    wait_idle();
  endtask

  task automatic t_clear();
    logic [7:0] v;
    int n;
    do_cmd(8'h04);
    do_cmd(8'h18);
    do_cmd(8'h7F);
    measure(1'b0, 1'b0, 8'h01, n);
    chk("R2 clear busy cycles", n, T_CLEAR);
    chk("R2 clear address", addr_cnt, 7'h00);
    chk("R2 clear offset", shift_ofs, 7'd0);
    chk("R2 clear forces increment", entry_inc, 1);
    chk("R2 R11 clear selects display", cg_target, 0);
    do_rd(v);
    chk("R2 blank at 0x00", v, 8'h20);
    do_cmd(8'hC0);
    do_rd(v);
    chk("R2 blank at 0x40", v, 8'h20);
    do_cmd(8'hA7);
    do_rd(v);
    chk("R2 blank at 0x27", v, 8'h20);
  endtask

  task automatic t_ignore_busy();
    logic [7:0] v;
    do_cmd(8'h85);
    send(1'b1, 1'b0, 8'h41);
    req_valid = 1'b1; req_data = 1'b1; req_read = 1'b0; req_byte = 8'h5A;
    @(negedge clk);
    req_data = 1'b0; req_byte = 8'hA0;
    @(negedge clk);
    req_byte = 8'h0F;
    @(negedge clk);
    req_byte = 8'h1C;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk("R9 address unchanged by busy requests", addr_cnt, 7'h06);
    chk("R9 display flag unchanged", disp_on, 0);
    chk("R9 offset unchanged", shift_ofs, 7'd0);
    do_rd(v);
    chk("R9 memory unchanged at 0x06", v, 8'h20);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_power_on();
    t_decode();
    t_two_line();
    t_one_line();
    t_glyph();
    t_entry_shift();
    t_shift_cmd();
    t_home();
    t_busy();
    t_clear();
    t_ignore_busy();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion within %0d cycles", WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule